// File: doc/BRIEF.md
# Interleaved Bank Access Scheduler

This block takes a stream of word addresses, such as the element addresses of a strided vector load or store, and spreads them across a set of single-ported memory banks. Consecutive word addresses fall in consecutive banks. Each bank stays occupied for a fixed number of cycles after an access starts. The request port can start at most one bank access per cycle. If the request at the head of the stream targets a bank that is still occupied, the request port deasserts ready. The requester holds that request, so no later address can overtake it.

The bank storage lives inside the block. Read data returns on a response port in the order the reads were accepted, exactly one bank latency after acceptance. Writes occupy their bank for the same time and return nothing. Because each bank is busy for a fixed time, throughput depends directly on the stride. A stride that is odd keeps every access on a free bank. A stride that shares factors with the bank count keeps coming back to a bank that is still busy.

Top module: `mbs_sched`

## Requirements
- R1: The bank index is the low 4 bits of the word address and the row inside the bank is the remaining upper bits. Every one of the 1024 word addresses holds its own value.
- R2: After an access to bank b is accepted on clock edge E, a further request to bank b sees ready low until it is accepted on edge E+11, not earlier.
- R3: A request to a bank that is not occupied is accepted in the same cycle, whatever the state of the other banks.
- R4: A read accepted on edge E raises rsp_valid for exactly one cycle, registered on edge E+11.
- R5: Read responses come back in acceptance order. Each response carries the word stored at its address.
- R6: A write (req_write=1) returns no response. A later read of the same address returns the written word.
- R7: A stream whose stride is odd (coprime with 16) is accepted one request per cycle, with no stall.
- R8: A stream with stride 16 targets a single bank and is accepted once every 11 cycles.
- R9: While rst is high, and in the first cycle after it falls, rsp_valid is low and every bank is free. A read in flight when reset rises never produces a response.
- R10: A stride of 2, 4 or 8 cycles through 8, 4 or 2 banks. The stream stalls when it returns to a bank within 11 cycles. For example, 16 reads at stride 2 have their last acceptance 18 cycles after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when req_valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle per read) |
| rsp_data | output | 32 | Read data |

## Verification
A bank counter that is off by one shows up at the ports at once. The same-bank request following it is accepted one edge early or late, so the acceptance spacing in R2 and R8, and the stall totals of the stride table, move immediately. A lost or misordered tag queue entry, or a bank done flag that is cleared wrongly, appears within 11 cycles of the read concerned as a missing, extra or mistimed rsp_valid, or as data belonging to another address. Reset faults show up in the first cycles after reset is released, as stray responses or a bank stuck busy.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
package mbs_pkg;
  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} mbs_op_e;
endpackage

// File: rtl/mbs_bank.sv
`timescale 1ns/1ps
// One single-ported bank: storage, occupancy counter and a read-complete flag.
module mbs_bank #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 32,
  parameter int LAT    = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  mbs_pkg::mbs_op_e    op,
  input  logic [ROW_W-1:0]    row,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                take,
  output logic                busy,
  output logic                rd_done,
  output logic [DATA_W-1:0]   rdata
);
  import mbs_pkg::*;

  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(LAT);

  logic [DATA_W-1:0] store [ROWS];
  logic [CNT_W-1:0]  cnt;
  logic              rd_pend;

  // Array access happens once, at start; the output register holds the word
  // until the occupancy window closes (block-RAM friendly).
  always_ff @(posedge clk) begin
    if (start && op == OP_WRITE) store[row] <= wdata;
    if (start && op == OP_READ)  rdata      <= store[row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rd_pend <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      if (start) begin
        cnt     <= CNT_W'(LAT - 1);
        rd_pend <= (op == OP_READ);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (take)
        rd_done <= 1'b0;
      else if (cnt == CNT_W'(1) && rd_pend)
        rd_done <= 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/mbs_tagq.sv
`timescale 1ns/1ps
// In-order queue of bank indices for reads awaiting their response.
module mbs_tagq #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [W-1:0]                din,
  input  logic                        pop,
  output logic [W-1:0]                dout,
  output logic                        empty,
  output logic                        full,
  output logic [$clog2(DEPTH):0]      count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  ent [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) ent[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = ent[rp];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/mbs_sched.sv
`timescale 1ns/1ps
// Word-interleaved bank scheduler: one access start per cycle, fixed bank
// occupancy, in-order read responses.
module mbs_sched #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int BANK_BITS = 4,
  parameter int LAT       = 11,
  parameter int QDEPTH    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  import mbs_pkg::*;

  localparam int NBANK = 1 << BANK_BITS;
  localparam int ROW_W = ADDR_W - BANK_BITS;

  logic [BANK_BITS-1:0] bank_sel;
  logic [ROW_W-1:0]     row_sel;
  logic [NBANK-1:0]     bank_busy;
  logic [NBANK-1:0]     bank_done;
  logic [DATA_W-1:0]    bank_rdata [NBANK];
  logic                 acc;
  logic                 q_empty, q_full, fire;
  logic [BANK_BITS-1:0] q_head;
  logic [$clog2(QDEPTH):0] q_count;
  mbs_op_e              op;

  assign bank_sel  = req_addr[BANK_BITS-1:0];
  assign row_sel   = req_addr[ADDR_W-1:BANK_BITS];
  assign op        = req_write ? OP_WRITE : OP_READ;
  assign req_ready = !rst && !bank_busy[bank_sel] && (req_write || !q_full);
  assign acc       = req_valid && req_ready;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    mbs_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W), .LAT(LAT)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .start   (acc && bank_sel == BANK_BITS'(b)),
      .op      (op),
      .row     (row_sel),
      .wdata   (req_wdata),
      .take    (fire && q_head == BANK_BITS'(b)),
      .busy    (bank_busy[b]),
      .rd_done (bank_done[b]),
      .rdata   (bank_rdata[b])
    );
  end

  mbs_tagq #(.DEPTH(QDEPTH), .W(BANK_BITS)) u_tagq (
    .clk   (clk),
    .rst   (rst),
    .push  (acc && !req_write),
    .din   (bank_sel),
    .pop   (fire),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full),
    .count (q_count)
  );

  assign fire = !q_empty && bank_done[q_head];

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= fire;
    if (fire) rsp_data <= bank_rdata[q_head];
  end
endmodule

// File: rtl/mbs_sched_chk.sv
`timescale 1ns/1ps
module mbs_sched_chk #(
  parameter int ADDR_W    = 10,
  parameter int BANK_BITS = 4,
  parameter int LAT       = 11,
  parameter int QDEPTH    = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_write,
  input logic [ADDR_W-1:0]        req_addr,
  input logic                     rsp_valid,
  input logic [$clog2(QDEPTH):0]  q_count
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam int CNT_W = $clog2(LAT);

  logic [CNT_W-1:0]     mdl_cnt [NBANK];
  logic [LAT:0]         rd_pipe;
  logic [BANK_BITS-1:0] bk;
  logic                 acc;

  assign bk  = req_addr[BANK_BITS-1:0];
  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pipe <= '0;
      for (int i = 0; i < NBANK; i++) mdl_cnt[i] <= '0;
    end else begin
      rd_pipe <= {rd_pipe[LAT-1:0], acc && !req_write};
      for (int i = 0; i < NBANK; i++) begin
        if (acc && bk == BANK_BITS'(i)) mdl_cnt[i] <= CNT_W'(LAT - 1);
        else if (mdl_cnt[i] != '0)      mdl_cnt[i] <= mdl_cnt[i] - 1'b1;
      end
    end
  end

  AST_NO_EARLY_REUSE: assert property (@(posedge clk) disable iff (rst)
    acc |-> mdl_cnt[bk] == '0); // R2
  AST_FREE_BANK_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mdl_cnt[bk] == '0) |-> req_ready); // R3
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_pipe[LAT] |-> rsp_valid); // R4
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !rd_pipe[LAT] |-> !rsp_valid); // R6
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
    q_count <= ($clog2(QDEPTH)+1)'(QDEPTH)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !rsp_valid); // R9
endmodule

bind mbs_sched mbs_sched_chk #(
  .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .LAT(LAT), .QDEPTH(QDEPTH)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .q_count(q_count)
);

// File: tb/sim_mbs_sched.sv
`timescale 1ns/1ps
module sim_mbs_sched;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NROW = 7;
  localparam int ROW_STRIDE [NROW] = '{1, 3, 5, 2, 4, 8, 16};
  localparam int ROW_N      [NROW] = '{16, 16, 20, 16, 8, 4, 4};
  localparam int ROW_BASE   [NROW] = '{0, 7, 100, 33, 64, 512, 5};
  localparam int ROW_SPAN   [NROW] = '{15, 15, 19, 18, 14, 12, 33};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic [DW-1:0] mdl [1024];
  logic [DW-1:0] ex_data [256];
  int            ex_cyc  [256];
  int            ex_wr = 0;
  int            ex_rd = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbs_sched u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hC3A50000 ^ (32'(a) * 32'h00010003);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Presents one request from a falling edge; returns the index of the
  // rising edge that accepted it. Leaves req_valid high.
  task automatic issue(input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output int acc);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    acc = cyc;
    if (w) mdl[a] = d;
    else begin
      ex_data[ex_wr % 256] = mdl[a];
      ex_cyc[ex_wr % 256]  = acc + 12;
      ex_wr++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Response monitor: order, data, timing, no stray responses.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (ex_rd == ex_wr)
        check(1'b0, "R6", "response without pending read", 1, 0);
      else begin
        check(rsp_data == ex_data[ex_rd % 256], "R5", "read data in order (R1 mapping)",
              longint'(rsp_data), longint'(ex_data[ex_rd % 256]));
        check(cyc == ex_cyc[ex_rd % 256], "R4", "response edge",
              cyc, ex_cyc[ex_rd % 256]);
        ex_rd++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int first, last, acc, a0, a1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R9", "bank free after reset", req_ready, 1);
    @(negedge clk);

    // R1 / R7: fill every word at stride 1 with distinct data, no stall.
    for (int a = 0; a < 1024; a++) begin
      issue(1'b1, AW'(a), pat(a), acc);
      if (a == 0) first = acc;
      last = acc;
    end
    check(last - first == 1023, "R7", "write fill span", last - first, 1023);
    idle(14);

    // Stride table: read streams, acceptance span per stride.
    for (int r = 0; r < NROW; r++) begin
      string tg;
      tg = (ROW_STRIDE[r] == 16) ? "R8" : ((ROW_STRIDE[r] % 2 == 1) ? "R7" : "R10");
      for (int k = 0; k < ROW_N[r]; k++) begin
        issue(1'b0, AW'(ROW_BASE[r] + k * ROW_STRIDE[r]), '0, acc);
        if (k == 0) first = acc;
        last = acc;
      end
      check(last - first == ROW_SPAN[r], tg, "stream acceptance span",
            last - first, ROW_SPAN[r]);
      idle(16);
    end

    // R2 / R3: busy bank blocks, free neighbour goes straight through.
    issue(1'b0, AW'(5), '0, a0);
    issue(1'b0, AW'(6), '0, a1);
    check(a1 - a0 == 1, "R3", "free bank accept edge", a1 - a0, 1);
    issue(1'b0, AW'(21), '0, a1);
    check(a1 - a0 == 11, "R2", "same bank accept edge", a1 - a0, 11);
    idle(16);

    // R6: write then read same word; write returns nothing, read sees it.
    issue(1'b1, AW'(100), 32'hDEADBEEF, a0);
    issue(1'b0, AW'(100), '0, a1);
    check(a1 - a0 == 11, "R2", "read after write same bank", a1 - a0, 11);
    idle(16);
    check(ex_rd == ex_wr, "R6", "responses drained", ex_rd, ex_wr);

    // R9: reset with a read in flight drops it and frees the bank.
    issue(1'b0, AW'(200), '0, a0);
    idle(3);
    rst = 1'b1;
    ex_rd = ex_wr;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    req_addr = AW'(200);
    #1;
    check(req_ready == 1'b1, "R9", "bank free after mid-run reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R9", "no response after reset", rsp_valid, 0);
    idle(16);
    check(ex_rd == ex_wr, "R5", "every read answered", ex_rd, ex_wr);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule